// File: doc/BRIEF.md
# ISA System Clock Divider with I/O Recovery Timer

This block makes the ISA system clock from the PCI clock and spaces out back-to-back ISA I/O commands. One configuration byte, held in the block, selects the divide ratio (4 or 3). It also holds two separate recovery settings, one for 8-bit and one for 16-bit I/O cycles. The recovery time is a baseline of three and a half system clocks plus a programmable number of whole system clocks. The half clock is counted as two PCI clocks for both ratios, so the gap is never shorter than programmed.

The ISA command sequencer pulses an end-of-command strobe and tags it with the cycle width. The recovery count starts at that strobe. While the count runs, a pending command request is not granted. The grant output goes high in the cycle after the request is sampled with the timer idle. A change of divide ratio is held back until the next rising edge of the system clock, so the ISA clock never shows a shortened pulse.

Top module: `isa_clk_recovery`

## Requirements
- R1: During reset `sys_clk` and `io_go` are low. The configuration byte resets to 8'h4D, which gives divide-by-4 and a recovery of 18 PCI clocks after both 8-bit and 16-bit cycles.
- R2: With configuration bit 7 at 0, `sys_clk` repeats a pattern of 2 PCI clocks high and 2 low. The first rising edge comes at the first clock edge after reset.
- R3: With configuration bit 7 at 1, `sys_clk` repeats a pattern of 2 PCI clocks high and 1 low.
- R4: A new value of bit 7 takes effect only where `sys_clk` rises. The low and high phase already running completes at the old ratio.
- R5: With bit 6 at 0, the recovery after an 8-bit cycle (`cmd_end_wide`=0) is 3*D+2 PCI clocks, where D is the divisor selected by bit 7 (4 or 3).
- R6: With bit 6 at 1, the recovery after an 8-bit cycle is (3+E)*D+2 PCI clocks, where E is bits 5:3 read as an unsigned binary number (0 to 7).
- R7: With bit 2 at 0, the recovery after a 16-bit cycle (`cmd_end_wide`=1) is 3*D+2 PCI clocks.
- R8: With bit 2 at 1, the recovery after a 16-bit cycle is (3+E)*D+2 PCI clocks, where E is 1, 2 or 3 for bits 1:0 = 01, 10, 11, and E is 4 for bits 1:0 = 00.
- R9: Suppose `cmd_end` is sampled at clock edge T with recovery length L and `cmd_req` stays high. Then `io_go` stays low after edges T through T+L and goes high after edge T+L+1. `io_go` is never high unless `cmd_req` was high at the preceding edge.
- R10: A strobe that arrives while a recovery is running restarts the count, using the length for the new strobe's width.
- R11: The length is set by the configuration byte held before the strobe's edge. A write at the same edge affects only later strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration byte |
| cfg_wdata | input | 8 | New configuration byte value |
| cmd_end | input | 1 | One-cycle pulse at the end of an ISA I/O command |
| cmd_end_wide | input | 1 | Width tag of the ending command: 1 = 16-bit, 0 = 8-bit |
| cmd_req | input | 1 | A new I/O command is waiting to start |
| sys_clk | output | 1 | Derived ISA system clock (registered) |
| io_go | output | 1 | Registered grant: the waiting command may start |

## Verification
Three things can land on the same PCI clock edge and must be resolved correctly. An end-of-command strobe can arrive at the same edge as a pending request. A configuration write can arrive at the same edge as a strobe. A change of divide ratio can arrive in the middle of a system clock period while a recovery is running. The bench raises the request in the same cycle as the strobe and checks that no grant comes from that edge. It writes a new byte at the strobe edge and checks that the measured gap still matches the old byte. It rewrites the ratio bit at random points and compares `sys_clk` on every cycle with a model that switches ratio only at a rising edge. Random strobes that restart a running recovery are checked against the length for the second strobe's width.

// File: rtl/isa_rcv_pkg.sv
package isa_rcv_pkg;
  localparam int EXT8_W  = 3;
  localparam int EXT16_W = 2;

  // Field layout follows the bit positions the timing behaviour decodes.
  typedef struct packed {
    logic               fast_div;  // bit 7: 1 -> divide by 3
    logic               ext8_en;   // bit 6
    logic [EXT8_W-1:0]  ext8;      // bits 5:3
    logic               ext16_en;  // bit 2
    logic [EXT16_W-1:0] ext16;     // bits 1:0, zero code means the largest step
  } rcv_cfg_t;
endpackage

// File: rtl/isa_sysclk_gen.sv
module isa_sysclk_gen #(
  parameter int DIV_SLOW = 4,
  parameter int DIV_FAST = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic fast_sel,
  output logic sys_clk
);
  localparam int PH_W       = $clog2(DIV_SLOW);
  localparam int HIGH_TICKS = (DIV_FAST + 1) / 2;

  logic [PH_W-1:0] phase_q;
  logic            fast_q;
  logic            sys_q;
  logic [PH_W-1:0] last_ph;
  logic [PH_W:0]   ph_inc;

  assign last_ph = fast_q ? PH_W'(DIV_FAST - 1) : PH_W'(DIV_SLOW - 1);
  assign ph_inc  = {1'b0, phase_q} + (PH_W+1)'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_W'(DIV_SLOW - 1);
      fast_q  <= 1'b0;
      sys_q   <= 1'b0;
    end else if (phase_q == last_ph) begin
      phase_q <= '0;
      fast_q  <= fast_sel;
      sys_q   <= 1'b1;
    end else begin
      phase_q <= ph_inc[PH_W-1:0];
      sys_q   <= (ph_inc < (PH_W+1)'(HIGH_TICKS));
    end
  end

  assign sys_clk = sys_q;

  // R2
  high_two_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_q) |=> sys_q);
  // R3
  high_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (sys_q && $past(sys_q)) |=> !sys_q);
  // R3
  fast_low_one_chk: assert property (@(posedge clk) disable iff (rst)
    (fast_q && $fell(sys_q)) |=> sys_q);
  // R4
  ratio_switch_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(fast_q) |-> $rose(sys_q));
endmodule

// File: rtl/isa_rcv_len.sv
module isa_rcv_len
  import isa_rcv_pkg::*;
#(
  parameter int DIV_SLOW    = 4,
  parameter int DIV_FAST    = 3,
  parameter int BASE_SYSCLK = 3,
  parameter int LEN_W       = 6
) (
  input  rcv_cfg_t         cfg,
  input  logic             wide,
  output logic [LEN_W-1:0] len
);
  logic [LEN_W-1:0] ext_w;
  logic [LEN_W-1:0] cand [2];

  always_comb begin
    if (wide) begin
      if (!cfg.ext16_en)      ext_w = '0;
      else if (cfg.ext16 == '0) ext_w = LEN_W'(1 << EXT16_W);
      else                     ext_w = LEN_W'(cfg.ext16);
    end else begin
      ext_w = cfg.ext8_en ? LEN_W'(cfg.ext8) : '0;
    end
  end

  // One candidate length per divide ratio; half system clock rounded up.
  for (genvar g = 0; g < 2; g++) begin : g_div
    localparam int D = (g == 0) ? DIV_SLOW : DIV_FAST;
    localparam int H = (D + 1) / 2;
    assign cand[g] = (LEN_W'(BASE_SYSCLK) + ext_w) * LEN_W'(D) + LEN_W'(H);
  end

  assign len = cfg.fast_div ? cand[1] : cand[0];
endmodule

// File: rtl/isa_rcv_timer.sv
module isa_rcv_timer #(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  input  logic             req,
  output logic             go
);
  logic [LEN_W-1:0] cnt_q;
  logic             go_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      go_q  <= 1'b0;
    end else begin
      go_q <= req && !load && (cnt_q == '0);
      if (load)
        cnt_q <= load_len;
      else if (cnt_q != '0)
        cnt_q <= cnt_q - LEN_W'(1);
    end
  end

  assign go = go_q;

  // R9
  no_go_after_end_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> !go_q);
  // R9
  go_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    go_q |-> $past(req));
  // R10
  countdown_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0 && !load) |=> (cnt_q == $past(cnt_q) - LEN_W'(1)));
  // R9
  hold_while_count_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |=> !go_q);
endmodule

// File: rtl/isa_clk_recovery.sv
module isa_clk_recovery
  import isa_rcv_pkg::*;
#(
  parameter logic [7:0] CFG_RST     = 8'h4D,
  parameter int         DIV_SLOW    = 4,
  parameter int         DIV_FAST    = 3,
  parameter int         BASE_SYSCLK = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  input  logic       cmd_end,
  input  logic       cmd_end_wide,
  input  logic       cmd_req,
  output logic       sys_clk,
  output logic       io_go
);
  localparam int MAX_EXT8  = (1 << EXT8_W) - 1;
  localparam int MAX_EXT16 = 1 << EXT16_W;
  localparam int MAX_EXT   = (MAX_EXT8 > MAX_EXT16) ? MAX_EXT8 : MAX_EXT16;
  localparam int MAX_LEN   = (BASE_SYSCLK + MAX_EXT) * DIV_SLOW + (DIV_SLOW + 1) / 2;
  localparam int MIN_LEN   = BASE_SYSCLK * DIV_FAST + (DIV_FAST + 1) / 2;
  localparam int LEN_W     = $clog2(MAX_LEN + 1);

  rcv_cfg_t         cfg_q;
  logic [LEN_W-1:0] rec_len;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= rcv_cfg_t'(CFG_RST);
    else if (cfg_we) cfg_q <= rcv_cfg_t'(cfg_wdata);
  end

  isa_sysclk_gen #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_clkgen (
    .clk      (clk),
    .rst      (rst),
    .fast_sel (cfg_q.fast_div),
    .sys_clk  (sys_clk)
  );

  isa_rcv_len #(
    .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST),
    .BASE_SYSCLK(BASE_SYSCLK), .LEN_W(LEN_W)
  ) u_len (
    .cfg  (cfg_q),
    .wide (cmd_end_wide),
    .len  (rec_len)
  );

  isa_rcv_timer #(.LEN_W(LEN_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (cmd_end),
    .load_len (rec_len),
    .req      (cmd_req),
    .go       (io_go)
  );

  // R6 R8
  rec_len_range_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_end |-> (rec_len >= LEN_W'(MIN_LEN) && rec_len <= LEN_W'(MAX_LEN)));
endmodule

// File: tb/sim_isa_clk_recovery.sv
module sim_isa_clk_recovery;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       cmd_end = 1'b0;
  logic       cmd_end_wide = 1'b0;
  logic       cmd_req = 1'b0;
  logic       sys_clk;
  logic       io_go;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [7:0] cur_cfg = 8'h4D;

  always #(PERIOD/2) clk = ~clk;

  isa_clk_recovery u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cmd_end(cmd_end), .cmd_end_wide(cmd_end_wide), .cmd_req(cmd_req),
    .sys_clk(sys_clk), .io_go(io_go)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_len(input logic [7:0] c, input logic wide);
    int d, e;
    d = c[7] ? 3 : 4;
    if (wide) e = c[2] ? ((c[1:0] == 2'b00) ? 4 : int'(c[1:0])) : 0;
    else      e = c[6] ? int'(c[5:3]) : 0;
    return (3 + e) * d + 2;
  endfunction

  // System clock reference model: ratio latched only at a rising edge.
  int   mph = 3, mdiv = 4;
  logic [7:0] mcfg = 8'h4D;
  logic exp_sys = 1'b0;
  bit   mon_on = 0;
  always @(posedge clk) begin
    if (rst) begin
      mph = 3; mdiv = 4; mcfg = 8'h4D; exp_sys = 1'b0; mon_on = 0;
    end else begin
      if (mph == mdiv - 1) begin mph = 0; mdiv = mcfg[7] ? 3 : 4; end
      else mph++;
      exp_sys = (mph < 2);
      if (cfg_we) mcfg = cfg_wdata;
      mon_on = 1;
    end
  end
  always @(negedge clk) begin
    if (mon_on && !rst)
      chk(sys_clk === exp_sys, (mdiv == 3) ? "R3 R4 sys_clk" : "R2 R4 sys_clk",
          int'(sys_clk), int'(exp_sys));
  end

  task automatic wr_cfg(input logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
    cur_cfg = v;
  endtask

  // Strobe (optionally after an earlier strobe, optionally with a same-edge write),
  // hold the request and count edges until the grant appears.
  task automatic run_rec(input logic wide, input logic first_wide, input int gap,
                         input logic wr_now, input logic [7:0] wr_val, input string tag);
    int exp, k;
    cmd_req = 1'b0;
    repeat (45) @(negedge clk);
    chk(io_go === 1'b0, "R9 idle no request", int'(io_go), 0);
    if (gap > 0) begin
      cmd_end = 1'b1; cmd_end_wide = first_wide;
      @(negedge clk); cmd_end = 1'b0;
      repeat (gap - 1) @(negedge clk);
    end
    cmd_end = 1'b1; cmd_end_wide = wide; cmd_req = 1'b1;
    if (wr_now) begin cfg_we = 1'b1; cfg_wdata = wr_val; end
    exp = exp_len(cur_cfg, wide) + 1;
    if (wr_now) cur_cfg = wr_val;
    @(negedge clk);
    cmd_end = 1'b0; cfg_we = 1'b0;
    chk(io_go === 1'b0, {tag, " R9 same-edge request"}, int'(io_go), 0);
    k = 0;
    while (k < 80) begin
      @(negedge clk);
      k++;
      if (io_go === 1'b1) break;
    end
    chk(k == exp, tag, k, exp);
    cmd_req = 1'b0;
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(sys_clk === 1'b0, "R1 reset sys_clk", int'(sys_clk), 0);
    chk(io_go === 1'b0, "R1 reset io_go", int'(io_go), 0);
    rst = 1'b0;

    // R1 reset byte: 18 clocks both widths
    run_rec(1'b0, 1'b0, 0, 1'b0, 8'h00, "R1 R6 reset 8-bit");
    run_rec(1'b1, 1'b0, 0, 1'b0, 8'h00, "R1 R8 reset 16-bit");
    // R5 R7 extensions disabled, divide by 4
    wr_cfg(8'h00);
    run_rec(1'b0, 1'b0, 0, 1'b0, 8'h00, "R5 8-bit base div4");
    run_rec(1'b1, 1'b0, 0, 1'b0, 8'h00, "R7 16-bit base div4");
    // R3 R5 divide by 3
    wr_cfg(8'h80);
    run_rec(1'b0, 1'b0, 0, 1'b0, 8'h00, "R5 R3 8-bit base div3");
    // R6 R8 largest extensions, zero code for 16-bit
    wr_cfg(8'h7C);
    run_rec(1'b0, 1'b0, 0, 1'b0, 8'h00, "R6 8-bit ext7");
    run_rec(1'b1, 1'b0, 0, 1'b0, 8'h00, "R8 16-bit code00");
    wr_cfg(8'h87);
    run_rec(1'b0, 1'b0, 0, 1'b0, 8'h00, "R5 8-bit disabled div3");
    run_rec(1'b1, 1'b0, 0, 1'b0, 8'h00, "R8 16-bit code11 div3");
    // R10 restart with the new width
    wr_cfg(8'h7C);
    run_rec(1'b1, 1'b0, 5, 1'b0, 8'h00, "R10 restart to 16-bit");
    run_rec(1'b0, 1'b1, 3, 1'b0, 8'h00, "R10 restart to 8-bit");
    // R11 write at the strobe edge
    run_rec(1'b0, 1'b0, 0, 1'b1, 8'h80, "R11 same-edge write");
    run_rec(1'b0, 1'b0, 0, 1'b0, 8'h00, "R11 later strobe new byte");

    for (int i = 0; i < 60; i++) begin
      logic [7:0] v;
      logic w, fw, wn;
      int g;
      v = 8'($urandom);
      w = 1'($urandom); fw = 1'($urandom); wn = 1'($urandom % 4 == 0);
      g = int'($urandom % 4);
      wr_cfg(v);
      run_rec(w, fw, g, wn, 8'($urandom), "R5 R6 R7 R8 R10 R11 random");
    end

    repeat (10) @(negedge clk);
    chk(io_go === 1'b0, "R9 no request after run", int'(io_go), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule